// File: doc/BRIEF.md
# Fourth-Order Sinc Decimation Filter

This block turns the one-bit stream of a delta-sigma modulator into signed conversion words. Each accepted stream bit counts as +1 (bit 1) or -1 (bit 0). Four running integrators work at the sample rate and four differencing stages work once per decimation period of R = 2^DECIM_LOG2 samples. Together they give a (sin x / x)^4 response whose -3 dB point is near a quarter of the word rate. The exact result is 4*DECIM_LOG2+1 bits wide. It is clipped at the positive end and cut down to its top OUT_W bits, so a stream of all ones gives the most positive code and all zeros gives the most negative.

A static-looking control pin picks the conversion style. With `mode_cont` low (one-shot) a word is released only after 4R fresh samples, and every integrator and difference register is then cleared, so no word carries history from an earlier conversion. With `mode_cont` high (continuous) the state is kept: after the first 4R samples following reset, one word comes out for every R samples. Samples arrive on a valid/ready stream and words leave on a valid/ready stream. Back-pressure rules: a waiting word holds still until taken. Samples keep flowing while it waits, except that the one sample which would finish a word-producing period is refused until the slot drains or drains in that same cycle.

Top module: `sinc4_decim`

## Requirements
- R1: While `rst_n` is low and right after it rises, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R2: A sample is taken when `in_valid` and `in_ready` are both 1; bit 1 counts as +1 and bit 0 as -1. The word equals the sum of h[k]*x[n-k], where x[n] is the newest sample and h is a run of R ones convolved with itself four times (4R-3 taps). It appears on `out_data` with `out_valid` high one clock after the sample that completes a period of R accepted samples.
- R3: The full-precision result has 4*DECIM_LOG2+1 bits; `out_data` is its top OUT_W bits, the dropped low bits discarded toward minus infinity.
- R4: A positive full-scale result (+R^4) is clipped to the largest code, so all-ones input gives 0x1FFFF and all-zeros input gives 0x20000 with OUT_W = 18.
- R5: With `mode_cont` = 0, a word is released only at the end of the fourth period after reset or after the previous word. All filter state is then zeroed, so each word depends on its own 4R samples only.
- R6: With `mode_cont` = 1, the state is never zeroed. Once 4R samples have passed since reset, every period of R samples yields a word.
- R7: `mode_cont` is acted on at the sample that completes a period; changing it mid-period alters nothing until then.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` hold. `in_ready` drops only when the pending sample would finish a word-producing period; otherwise it stays 1.
- R9: When the held word is taken in the same cycle as a new word is formed, the new word replaces it and `out_valid` stays 1.
- R10: Cycles with `in_valid` = 0 change neither the sample count nor the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cont | input | 1 | 1 keeps state (continuous), 0 clears per word (one-shot) |
| in_valid | input | 1 | Sample present on `in_bit` |
| in_ready | output | 1 | Filter can take the sample |
| in_bit | input | 1 | Modulator bit |
| out_valid | output | 1 | Word present on `out_data` |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | OUT_W | Two's-complement conversion word |

## Verification
The two functions that can land in one cycle are the draining of a held word and the forming of the next one. The bench holds `out_ready` low through a whole continuous period and raises it exactly on the sample that closes the next period. The model then expects `out_valid` to stay high with the new word in place. A second coincidence is word release with the one-shot clear. The all-ones and all-zeros runs in one-shot mode would show stale history as a wrong full-scale code.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
  localparam int unsigned SINC_ORDER   = 4;
  localparam int unsigned WORD_W_DFLT  = 18;
  localparam int unsigned WARM_PERIODS = SINC_ORDER - 1;
endpackage

// File: rtl/sinc4_integ.sv
module sinc4_integ #(
  parameter int unsigned W     = 46,
  parameter int unsigned ORDER = sinc4_pkg::SINC_ORDER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clear,
  input  logic         bit_in,
  output logic [W-1:0] sum_out
);
  logic [W-1:0] acc_q [ORDER];
  logic [W-1:0] nxt   [ORDER];
  logic [W-1:0] x_val;

  // +1 for a one, -1 (all ones) for a zero
  assign x_val = bit_in ? W'(1) : {W{1'b1}};

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign nxt[s] = acc_q[s] + x_val;
    end else begin : g_rest
      assign nxt[s] = acc_q[s] + nxt[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q[s] <= '0;
      else if (step)  acc_q[s] <= clear ? '0 : nxt[s];
    end
  end

  assign sum_out = nxt[ORDER-1];
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb #(
  parameter int unsigned W     = 46,
  parameter int unsigned ORDER = sinc4_pkg::SINC_ORDER
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] dly_q [ORDER];
  logic [W-1:0] diff  [ORDER];
  logic [W-1:0] src   [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign src[s] = din;
    end else begin : g_rest
      assign src[s] = diff[s-1];
    end
    assign diff[s] = src[s] - dly_q[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dly_q[s] <= '0;
      else if (fire)  dly_q[s] <= clear ? '0 : src[s];
    end
  end

  assign dout = diff[ORDER-1];
endmodule

// File: rtl/sinc4_ctrl.sv
module sinc4_ctrl #(
  parameter int unsigned DECIM_LOG2 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_cont,
  input  logic in_valid,
  input  logic out_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic step,
  output logic fire,
  output logic emit,
  output logic clear
);
  localparam logic [1:0] WARM_DONE = 2'(sinc4_pkg::WARM_PERIODS);

  logic [DECIM_LOG2-1:0] cnt_q;
  logic [1:0]            warm_q;
  logic                  last_in_period;
  logic                  settled;

  assign last_in_period = &cnt_q;
  assign settled        = (warm_q == WARM_DONE);
  assign in_ready       = !(last_in_period && settled && out_valid && !out_ready);
  assign step           = in_valid && in_ready;
  assign fire           = step && last_in_period;
  assign emit           = fire && settled;
  assign clear          = emit && !mode_cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warm_q <= '0;
    end else begin
      if (step) cnt_q <= cnt_q + 1'b1;
      if (fire) begin
        if (!settled)       warm_q <= warm_q + 2'd1;
        else if (!mode_cont) warm_q <= '0;
      end
    end
  end
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim #(
  parameter int unsigned DECIM_LOG2 = 11,
  parameter int unsigned OUT_W      = sinc4_pkg::WORD_W_DFLT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cont,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned ACC_W = sinc4_pkg::SINC_ORDER * DECIM_LOG2 + 1;
  localparam int unsigned INT_W = ACC_W + 1;
  localparam logic [INT_W-1:0] POS_LIMIT = {2'b00, {(ACC_W-1){1'b1}}};

  logic             step, fire, emit, clear;
  logic [INT_W-1:0] integ_sum, comb_out, clipped;
  logic [OUT_W-1:0] word;

  sinc4_ctrl #(.DECIM_LOG2(DECIM_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .in_valid(in_valid),
    .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
    .step(step), .fire(fire), .emit(emit), .clear(clear)
  );

  sinc4_integ #(.W(INT_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clear),
    .bit_in(in_bit), .sum_out(integ_sum)
  );

  sinc4_comb #(.W(INT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clear(clear),
    .din(integ_sum), .dout(comb_out)
  );

  // only +R^4 can exceed the ACC_W signed range
  assign clipped = ($signed(comb_out) > $signed(POS_LIMIT)) ? POS_LIMIT : comb_out;

  if (ACC_W >= OUT_W) begin : g_trunc
    assign word = clipped[ACC_W-1 -: OUT_W];
  end else begin : g_pad
    assign word = {clipped[ACC_W-1:0], {(OUT_W-ACC_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sinc4_decim_chk.sv
module sinc4_decim_chk #(
  parameter int unsigned DECIM_LOG2 = 11,
  parameter int unsigned OUT_W      = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_cont,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_bit,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  localparam int unsigned SEEN_W = DECIM_LOG2 + 3;
  localparam logic [SEEN_W-1:0] SETTLE = SEEN_W'(4) << DECIM_LOG2;

  logic [SEEN_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid && in_ready && seen_q != SETTLE) seen_q <= seen_q + 1'b1;
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid); // R9
  AST_WORD_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R2
  AST_SETTLED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> seen_q == SETTLE); // R5
endmodule

bind sinc4_decim sinc4_decim_chk #(.DECIM_LOG2(DECIM_LOG2), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .in_valid(in_valid),
  .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_sinc4_decim.sv
module test_sinc4_decim;
  localparam int L     = 5;
  localparam int R     = 1 << L;
  localparam int NT    = 4 * R;
  localparam int OUT_W = 18;
  localparam int ACC_W = 4 * L + 1;
  localparam int SH    = ACC_W - OUT_W;
  localparam int MAXV  = (1 << (ACC_W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_cont = 1'b0, in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [OUT_W-1:0] out_data;

  always #2 clk = ~clk;

  sinc4_decim #(.DECIM_LOG2(L), .OUT_W(OUT_W)) i_sinc4_decim (
    .clk(clk), .rst_n(rst_n), .mode_cont(mode_cont), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int h [NT];
  int hist [NT];
  int m_cnt = 0, m_warm = 0, m_od = 0;
  bit m_ov = 0;

  function automatic bit m_ready();
    return !(m_ov && !out_ready && m_cnt == R-1 && m_warm == 3);
  endfunction

  task automatic compare(input string tag);
    logic [OUT_W-1:0] exp_d;
    exp_d = OUT_W'(m_od);
    vectors++;
    if (in_ready !== m_ready() || out_valid !== m_ov || out_data !== exp_d) begin
      miscompares++;
      $display("FAIL %s: ready %b exp %b, valid %b exp %b, data %h exp %h",
               tag, in_ready, m_ready(), out_valid, m_ov, out_data, exp_d);
    end
  endtask

  task automatic model_step();
    bit acc, pop, fresh;
    longint y;
    acc = in_valid && m_ready();
    pop = m_ov && out_ready;
    fresh = 0;
    if (acc) begin
      for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = in_bit ? 1 : -1;
      if (m_cnt == R-1) begin
        if (m_warm == 3) begin
          y = 0;
          for (int k = 0; k < NT; k++) y += longint'(h[k]) * hist[k];
          if (y > MAXV) y = MAXV;
          m_od = int'(y >>> SH);
          fresh = 1;
          if (!mode_cont) begin
            for (int k = 0; k < NT; k++) hist[k] = 0;
            m_warm = 0;
          end
        end else m_warm++;
      end
      m_cnt = (m_cnt + 1) % R;
    end
    if (fresh) m_ov = 1;
    else if (pop) m_ov = 0;
  endtask

  // pat: 0 random, 1 ones, 2 zeros, 3 alternating; coin: raise ready only on closing sample
  task automatic run_phase(input string tag, input int n, input int mode, input int pv,
                           input int pr, input int pat, input bit coin, input int flip);
    bit alt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flip > 0 && (i % flip) == 0) mode_cont = ~mode_cont;
      else if (flip == 0) mode_cont = mode[0];
      in_valid = ($urandom_range(99) < pv);
      case (pat)
        1: in_bit = 1'b1;
        2: in_bit = 1'b0;
        3: begin in_bit = alt; if (in_valid) alt = ~alt; end
        default: in_bit = $urandom_range(1);
      endcase
      if (coin) out_ready = (m_cnt == R-1) && in_valid;
      else      out_ready = ($urandom_range(99) < pr);
      #1;
      compare(tag);
      model_step();
    end
  endtask

  initial begin
    int tmp [NT];
    for (int k = 0; k < NT; k++) h[k] = (k == 0);
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < NT; k++) begin
        tmp[k] = 0;
        for (int j = 0; j < R && j <= k; j++) tmp[k] += h[k-j];
      end
      for (int k = 0; k < NT; k++) h[k] = tmp[k];
    end
    for (int k = 0; k < NT; k++) hist[k] = 0;

    repeat (3) begin @(negedge clk); #1; compare("R1"); end
    rst_n = 1'b1;
    @(negedge clk); #1; compare("R1");

    run_phase("R2",  1200, 0, 100, 100, 0, 0, 0);
    run_phase("R10", 1500, 0,  60, 100, 0, 0, 0);
    run_phase("R4",  3*NT+10, 0, 100, 100, 1, 0, 0);
    run_phase("R4",  3*NT+10, 0, 100, 100, 2, 0, 0);
    run_phase("R3",  3*NT+10, 0, 100, 100, 3, 0, 0);
    run_phase("R5",  1500, 0,  80,  70, 0, 0, 0);
    run_phase("R6",  1500, 1,  90, 100, 0, 0, 0);
    run_phase("R8",  2500, 1,  90,  30, 0, 0, 0);
    run_phase("R9",  2000, 1, 100,   0, 0, 1, 0);
    run_phase("R7",  3000, 0,  90,  80, 0, 0, 45);
    run_phase("R6",  3*NT, 1, 100, 100, 1, 0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule